// File: doc/BRIEF.md
# Frame-Locked Audio Clock Cycle Counter

This block measures an audio master clock against the USB frame rate. A free-running 16-bit counter counts rising edges of one of two divided master clocks. When a start-of-frame pulse arrives, the block copies the count into a capture register. Firmware reads that register as two bytes and subtracts consecutive captures to see how many audio clock cycles fit into one host frame. From that figure it can judge drift.

The block also has two integer clock dividers. The output divider takes the internally synthesized master clock and drives the primary master-clock pin. The input divider takes one of two external master-clock inputs and produces the secondary master clock. A single enable bit starts both dividers. Firmware sets the input select, the count-source select and the pin enable first, then sets the enable bit last.

All logic runs on the fast system clock `clk`. The audio clocks are slower than `clk` and are handled as sampled levels: their edges are detected, counted and divided. The start-of-frame pulse comes from elsewhere, so it passes through a synchronizer before its rising edge is detected.

Top module: `sfcap_top`

## Requirements
- R1: After reset, all four registers read 0x00 and the outputs `mclk_pri_o`, `mclk_pri_oe_o` and `mclk_sec_o` are low.
- R2: The register map is:
  - address 0 is control: bit 0 is divider enable, bit 1 is input select, bit 2 is count-source select, bit 3 is pin enable.
  - address 1 is divider setup: bits 3:0 are the output ratio code, bits 6:4 are the input ratio code.
  - addresses 2 and 3 are the capture low and high bytes, and both are read-only.
  
  Unused bits read as 0. A write to address 2 or 3 changes nothing.
- R3: With output ratio code n, the output divider produces one period for every n+1 periods of `mclk_int_i`. The output is high for exactly half of each period, measured in source half-periods. Code 0 passes the source through unchanged.
- R4: With input ratio code m, the input divider divides the selected external input by m+1, with the same duty rule as R3. Input select 0 picks `mclk_ext_a_i` and 1 picks `mclk_ext_b_i`.
- R5: While divider enable is 0, `mclk_pri_o` and `mclk_sec_o` stay low and the cycle counter does not advance.
- R6: `mclk_pri_oe_o` follows the pin-enable bit. While pin enable is 0, `mclk_pri_o` is low, but the counter keeps counting the output divider's clock.
- R7: With count-source select 0, the counter counts rising edges of the output divider's clock. With select 1, it counts rising edges of the input divider's clock.
- R8: Each rising edge of `sof_i` causes exactly one capture, however long the pulse lasts. A capture never clears the counter. The counter wraps modulo 2^16, and an edge that falls in the capture cycle is still counted.
- R9: The 16-bit capture is written as one unit, so the two bytes read after a frame pulse always come from the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the addressed register (combinational) |
| sof_i | input | 1 | Start-of-frame pulse; capture happens on its rising edge |
| mclk_int_i | input | 1 | Internally synthesized master clock, the source of the output divider |
| mclk_ext_a_i | input | 1 | External master clock input A |
| mclk_ext_b_i | input | 1 | External master clock input B |
| mclk_pri_o | output | 1 | Primary master clock out (output divider, gated by pin enable) |
| mclk_pri_oe_o | output | 1 | Drive enable for the primary master clock pin |
| mclk_sec_o | output | 1 | Secondary master clock (input divider output) |

## Verification
A counted edge of the selected clock and a capture of the count can fall in the same cycle. The design must then store the count from before the edge and still add the edge to the running total.

The bench provokes this collision in two ways:
- With the counted clock at its fastest rate, so that every second cycle carries an edge and any frame pulse lands on one half of the time.
- By holding a frame pulse high for twenty cycles.

Each case is judged at the register interface. Two frame pulses are sent exactly D cycles apart, where D is a multiple of the counted period. The difference between the two captures must equal D divided by that period. A lost edge, a capture that clears the counter, or a second capture during a long pulse each shifts that difference.

// File: rtl/sfcap_pkg.sv
package sfcap_pkg;

    localparam int BYTE_W = 8;
    localparam int CAP_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_DIV    = 2'd1,
        ADDR_CAP_LO = 2'd2,
        ADDR_CAP_HI = 2'd3
    } reg_addr_e;

    // Control byte: bit 3 pin_en, bit 2 cnt_sel, bit 1 in_sel, bit 0 div_en
    typedef struct packed {
        logic pin_en;
        logic cnt_sel;
        logic in_sel;
        logic div_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[CTRL_W-1:0] = c;
        return b;
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/sfcap_regs.sv
module sfcap_regs
    import sfcap_pkg::*;
#(
    parameter int OUT_DIV_W = 4,
    parameter int IN_DIV_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [CAP_W-1:0]     cap_val,
    output logic [BYTE_W-1:0]    rdata,
    output ctrl_t                ctrl,
    output logic [OUT_DIV_W-1:0] out_code,
    output logic [IN_DIV_W-1:0]  in_code
);

    localparam int DIV_FIELDS_W = OUT_DIV_W + IN_DIV_W;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            out_code <= '0;
            in_code  <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                ADDR_CTRL: ctrl <= byte_to_ctrl(wdata);
                ADDR_DIV: begin
                    out_code <= wdata[OUT_DIV_W-1:0];
                    in_code  <= wdata[DIV_FIELDS_W-1:OUT_DIV_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            ADDR_CTRL: rdata = ctrl_to_byte(ctrl);
            ADDR_DIV: begin
                rdata[OUT_DIV_W-1:0]            = out_code;
                rdata[DIV_FIELDS_W-1:OUT_DIV_W] = in_code;
            end
            ADDR_CAP_LO: rdata = cap_val[BYTE_W-1:0];
            ADDR_CAP_HI: rdata = cap_val[CAP_W-1:BYTE_W];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/sfcap_clkdiv.sv
module sfcap_clkdiv #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              src,
    input  logic [CODE_W-1:0] code,
    output logic              clk_o
);

    logic              src_q;
    logic [CODE_W-1:0] edge_cnt;
    logic              tog_q;
    logic              src_edge;

    assign src_edge = src ^ src_q;

    // Toggle after every code+1 source edges (rise or fall):
    // period = code+1 source periods, high for exactly half of it.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= 1'b0;
            edge_cnt <= '0;
            tog_q    <= 1'b0;
        end else begin
            src_q <= src;
            if (!en) begin
                edge_cnt <= '0;
                tog_q    <= 1'b0;
            end else if (src_edge) begin
                if (edge_cnt >= code) begin
                    edge_cnt <= '0;
                    tog_q    <= ~tog_q;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (!en)
            clk_o = 1'b0;
        else if (code == '0)
            clk_o = src;
        else
            clk_o = tog_q;
    end

endmodule

// File: rtl/sfcap_capture.sv
module sfcap_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clk,
    input  logic             sof,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             sof_evt_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sof_prev_q;
    logic                   cnt_clk_q;
    logic                   cnt_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sof};
        end
    end

    assign sof_evt_o = sync_q[SYNC_STAGES-1] & ~sof_prev_q;
    assign cnt_rise  = cnt_clk & ~cnt_clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sof_prev_q <= 1'b0;
            cnt_clk_q  <= 1'b0;
            cnt_o      <= '0;
            cap_o      <= '0;
        end else begin
            sof_prev_q <= sync_q[SYNC_STAGES-1];
            cnt_clk_q  <= cnt_clk;
            cnt_o      <= cnt_o + CNT_W'(cnt_rise);
            if (sof_evt_o)
                cap_o <= cnt_o;
        end
    end

endmodule

// File: rtl/sfcap_top.sv
module sfcap_top
    import sfcap_pkg::*;
#(
    parameter int OUT_DIV_W   = 4,
    parameter int IN_DIV_W    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sof_i,
    input  logic       mclk_int_i,
    input  logic       mclk_ext_a_i,
    input  logic       mclk_ext_b_i,
    output logic       mclk_pri_o,
    output logic       mclk_pri_oe_o,
    output logic       mclk_sec_o
);

    ctrl_t                ctrl;
    logic [OUT_DIV_W-1:0] out_code;
    logic [IN_DIV_W-1:0]  in_code;
    logic [CAP_W-1:0]     cnt_w;
    logic [CAP_W-1:0]     cap_w;
    logic                 sof_evt_w;
    logic                 div_en_w;
    logic                 in_src;
    logic                 pri_raw;
    logic                 sec_raw;
    logic                 cnt_clk;

    assign div_en_w = ctrl.div_en;

    sfcap_regs #(
        .OUT_DIV_W (OUT_DIV_W),
        .IN_DIV_W  (IN_DIV_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cap_val  (cap_w),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .out_code (out_code),
        .in_code  (in_code)
    );

    assign in_src = ctrl.in_sel ? mclk_ext_b_i : mclk_ext_a_i;

    sfcap_clkdiv #(.CODE_W(OUT_DIV_W)) u_div_out (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl.div_en),
        .src   (mclk_int_i),
        .code  (out_code),
        .clk_o (pri_raw)
    );

    sfcap_clkdiv #(.CODE_W(IN_DIV_W)) u_div_in (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl.div_en),
        .src   (in_src),
        .code  (in_code),
        .clk_o (sec_raw)
    );

    assign cnt_clk = ctrl.cnt_sel ? sec_raw : pri_raw;

    sfcap_capture #(
        .CNT_W       (CAP_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cnt_clk   (cnt_clk),
        .sof       (sof_i),
        .cnt_o     (cnt_w),
        .cap_o     (cap_w),
        .sof_evt_o (sof_evt_w)
    );

    assign mclk_pri_o    = pri_raw & ctrl.pin_en;
    assign mclk_pri_oe_o = ctrl.pin_en;
    assign mclk_sec_o    = sec_raw;

endmodule

// File: rtl/sfcap_chk.sv
module sfcap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             div_en,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             pri_o,
    input logic             pri_oe,
    input logic             sec_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic             sof_evt
);

    // R6: the pin is never high while its drive enable is low
    p_pin_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !pri_oe |-> !pri_o);

    // R5: disabled dividers keep both clocks low
    p_div_off_low_r5: assert property (@(posedge clk) disable iff (rst)
        (!div_en && $past(!div_en)) |-> (!pri_o && !sec_o));

    // R5: the counter holds while the dividers are disabled
    p_div_off_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!div_en) |-> $stable(cnt));

    // R8: the counter advances by at most one per cycle and never jumps back
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));

    // R8: the capture changes only after a frame event
    p_cap_on_evt_r8: assert property (@(posedge clk) disable iff (rst)
        (cap != $past(cap)) |-> $past(sof_evt));

    // R2: unused control bits read as zero
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[7:4] == 4'd0));

endmodule

bind sfcap_top sfcap_chk #(.CNT_W(sfcap_pkg::CAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_en    (div_en_w),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pri_o     (mclk_pri_o),
    .pri_oe    (mclk_pri_oe_o),
    .sec_o     (mclk_sec_o),
    .cnt       (cnt_w),
    .cap       (cap_w),
    .sof_evt   (sof_evt_w)
);

// File: tb/sfcap_top_tb.sv
module sfcap_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sof_i = 1'b0;
    logic       mclk_int_i = 1'b0;
    logic       mclk_ext_a_i = 1'b0;
    logic       mclk_ext_b_i = 1'b0;
    logic       mclk_pri_o;
    logic       mclk_pri_oe_o;
    logic       mclk_sec_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sfcap_top u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sof_i         (sof_i),
        .mclk_int_i    (mclk_int_i),
        .mclk_ext_a_i  (mclk_ext_a_i),
        .mclk_ext_b_i  (mclk_ext_b_i),
        .mclk_pri_o    (mclk_pri_o),
        .mclk_pri_oe_o (mclk_pri_oe_o),
        .mclk_sec_o    (mclk_sec_o)
    );

    // Audio sources: internal toggles every cycle (period 2),
    // ext A half-period 3 (period 6), ext B half-period 5 (period 10).
    int ph_a = 0;
    int ph_b = 0;
    always @(negedge clk) begin
        mclk_int_i <= ~mclk_int_i;
        if (ph_a == 2) begin ph_a <= 0; mclk_ext_a_i <= ~mclk_ext_a_i; end
        else ph_a <= ph_a + 1;
        if (ph_b == 4) begin ph_b <= 0; mclk_ext_b_i <= ~mclk_ext_b_i; end
        else ph_b <= ph_b + 1;
    end

    // Vectors: out_code, in_code, in_sel, pri period, pri high, sec period, sec high
    localparam int NVEC = 4;
    localparam int VEC [NVEC][7] = '{
        '{ 0, 0, 0,  2,  1,  6,  3},
        '{ 3, 1, 0,  8,  4, 12,  6},
        '{15, 7, 1, 32, 16, 80, 40},
        '{ 2, 4, 1,  6,  3, 50, 25}
    };

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? mclk_pri_o : mclk_sec_o;
    endfunction

    task automatic sample(input int which, output logic v);
        @(posedge clk);
        #2;
        v = pick(which);
    endtask

    task automatic measure(input int which, output int per, output int hi);
        logic v;
        int guard;
        int lo;
        per = 0; hi = 0; lo = 0;
        guard = 0;
        do begin sample(which, v); guard++; end while (v && guard < 500);
        guard = 0;
        do begin sample(which, v); guard++; end while (!v && guard < 500);
        hi = 1;
        guard = 0;
        forever begin
            sample(which, v); guard++;
            if (!v || guard > 500) break;
            hi++;
        end
        lo = 1;
        guard = 0;
        forever begin
            sample(which, v); guard++;
            if (v || guard > 500) break;
            lo++;
        end
        per = hi + lo;
    endtask

    task automatic read_cap(output int c);
        int lo;
        int hi;
        reg_read(2'd2, lo);
        reg_read(2'd3, hi);
        c = (hi << 8) | lo;
    endtask

    // Two frame pulses exactly d cycles apart; second one lasts len2 cycles.
    task automatic sof_pair(input int d, input int len2, output int c1, output int c2);
        @(negedge clk); sof_i = 1'b1;
        @(negedge clk); sof_i = 1'b0;
        repeat (8) @(negedge clk);
        read_cap(c1);
        repeat (d - 11) @(negedge clk);
        sof_i = 1'b1;
        repeat (len2) @(negedge clk);
        sof_i = 1'b0;
        repeat (8) @(negedge clk);
        read_cap(c2);
    endtask

    function automatic int delta16(input int a, input int b);
        return (b - a) & 16'hFFFF;
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int d;
        int per;
        int hi;
        int c1;
        int c2;
        logic v;
        logic any_hi;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), d);
            check($sformatf("R1 reg %0d after reset", a), d, 0);
        end
        check("R1 primary clock low", int'(mclk_pri_o), 0);
        check("R1 pin enable low", int'(mclk_pri_oe_o), 0);
        check("R1 secondary clock low", int'(mclk_sec_o), 0);

        // R2: unused bits read 0, capture bytes read-only
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, d);
        check("R2 divider byte unused bit", d, 8'h7F);
        reg_write(2'd0, 8'hF0);
        reg_read(2'd0, d);
        check("R2 control unused bits", d, 8'h00);
        reg_write(2'd2, 8'hAA);
        reg_write(2'd3, 8'h55);
        read_cap(d);
        check("R2 capture write ignored", d, 0);

        // R3/R4: divider vectors
        for (int i = 0; i < NVEC; i++) begin
            reg_write(2'd1, 8'((VEC[i][1] << 4) | VEC[i][0]));
            reg_write(2'd0, 8'(8 | (VEC[i][2] << 1)));
            reg_write(2'd0, 8'(8 | (VEC[i][2] << 1) | 1));
            reg_read(2'd0, d);
            check("R2 control readback", d, 8 | (VEC[i][2] << 1) | 1);
            repeat (40) @(negedge clk);
            measure(0, per, hi);
            check($sformatf("R3 vec %0d output period", i), per, VEC[i][3]);
            check($sformatf("R3 vec %0d output high time", i), hi, VEC[i][4]);
            measure(1, per, hi);
            check($sformatf("R4 vec %0d input period", i), per, VEC[i][5]);
            check($sformatf("R4 vec %0d input high time", i), hi, VEC[i][6]);
        end

        // R5: dividers disabled
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h08);
        repeat (5) @(negedge clk);
        any_hi = 1'b0;
        for (int k = 0; k < 30; k++) begin
            sample(0, v); any_hi |= v;
            sample(1, v); any_hi |= v;
        end
        check("R5 clocks low when disabled", int'(any_hi), 0);
        sof_pair(300, 1, c1, c2);
        check("R5 no counting when disabled", delta16(c1, c2), 0);

        // R6: pin disabled, counter still counts output divider (period 4)
        reg_write(2'd1, 8'h01);
        reg_write(2'd0, 8'h01);
        repeat (10) @(negedge clk);
        any_hi = 1'b0;
        for (int k = 0; k < 20; k++) begin
            sample(0, v); any_hi |= v | mclk_pri_oe_o;
        end
        check("R6 pin low and undriven", int'(any_hi), 0);
        sof_pair(400, 1, c1, c2);
        check("R6 R7 count output divider with pin off", delta16(c1, c2), 100);

        // R7/R4: count source = input divider, ext A (period 6), then ext B (period 10)
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h0D);
        repeat (10) @(negedge clk);
        sof_pair(600, 1, c1, c2);
        check("R7 count input divider ext A", delta16(c1, c2), 100);
        reg_write(2'd0, 8'h0F);
        repeat (10) @(negedge clk);
        sof_pair(600, 1, c1, c2);
        check("R7 R4 count input divider ext B", delta16(c1, c2), 60);

        // R8: long frame pulse captures once; edges every second cycle
        reg_write(2'd0, 8'h09);
        repeat (10) @(negedge clk);
        sof_pair(400, 20, c1, c2);
        check("R8 long pulse single capture", delta16(c1, c2), 200);
        sof_pair(402, 1, c1, c2);
        check("R8 odd spacing count", delta16(c1, c2), 201);

        // R8/R9: wrap past 2^16, both bytes from the same sample
        sof_pair(2 * 65536 + 14, 1, c1, c2);
        check("R8 wrap modulo 2^16", delta16(c1, c2), 7);
        check("R9 high byte consistent", (c2 >> 8) & 8'hFF, ((c1 + 7) >> 8) & 8'hFF);
        check("R9 low byte consistent", c2 & 8'hFF, (c1 + 7) & 8'hFF);

        done = 1'b1;
        report();
        $finish;
    end

endmodule